// File: doc/BRIEF.md
# CAN Interrupt Flag and Priority-Code Unit

This block sits between a CAN controller core and the CPU. It catches single-cycle event pulses from the core and holds each one in a sticky flag bit. The events are receive-buffer-loaded, transmit-buffer-empty, error causes, bus activity during sleep and message error. A second register of the same width holds one enable bit per flag. From flags and enables the block drives one combined interrupt request and a small priority code. The code names the most urgent pending enabled source, so software can jump straight to a handler.

Six distinct error conditions are merged into a single error flag. Each condition also sets its own bit in a separate error-cause register, so software can tell which condition fired. Flags and cause bits are cleared only by software writing zero to the bit. A hardware event in the same cycle as a clear takes precedence. The buffer counts, the number of error causes, the code width and the reset style are parameters that are checked when the design is elaborated.

Top module: `can_irq_unit`

## Requirements
- R1: After reset the flag register, the enable register and the error-cause register all read 0, `irq` is 0 and `icode` is 000.
- R2: A pulse on `ev_tx_empty[k]` sets flag bit 2+k (TX buffer k, k=0..2). A pulse on `ev_rx_done[k]` sets flag bit k (RX buffer k, k=0..1). Each becomes visible in the cycle after the pulse.
- R3: A pulse on any bit of `ev_err_cause` sets the error flag (bit 5) and sets the same bit of the error-cause register. The cause bits are 0 RX overrun, 1 RX warning, 2 RX error-passive, 3 TX warning, 4 TX error-passive and 5 bus-off. A write of 0 to a cause bit clears it, and clearing the error flag leaves the cause register unchanged.
- R4: A pulse on `ev_msg_err` sets the message-error flag (bit 7). This flag never affects `icode`.
- R5: The wake-up flag (bit 6) is set only when `ev_bus_act`, `sleep_mode` and enable bit 6 are all 1 in the same cycle.
- R6: A flag stays set until the CPU writes 0 to its bit position. Writing 1 to a flag bit has no effect.
- R7: When a hardware set and a CPU clear hit the same flag in the same cycle, the flag ends up set.
- R8: `icode` uses a fixed order, where a lower nonzero code means higher priority: 001 error, 010 wake-up, 011 TX0, 100 TX1, 101 TX2, 110 RX0, 111 RX1.
- R9: Only flags whose enable bit is 1 take part in `icode`. When no coded source is both pending and enabled, `icode` reads 000.
- R10: When the highest-priority pending source is cleared, `icode` changes in the same cycle to the next pending enabled source.
- R11: `irq` is 1 exactly when some flag, including the message-error flag, is set together with its enable bit.
- R12: The register addresses are: address 0 is the flags (write-zero-to-clear), address 1 is the enables (read/write), and address 2 is the error-cause register (write-zero-to-clear). Reads are combinational from `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_rx_done | input | N_RX | Receive-complete pulse per RX buffer |
| ev_tx_empty | input | N_TX | Buffer-empty pulse per TX buffer |
| ev_err_cause | input | N_ERR | Error-condition pulses |
| ev_msg_err | input | 1 | Frame error during send or receive |
| ev_bus_act | input | 1 | Bus activity detected |
| sleep_mode | input | 1 | Device is in sleep |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data |
| irq | output | 1 | Combined interrupt request |
| icode | output | CODE_W | Priority code of the top pending enabled source |

## Verification
The checker checks the following on every cycle:
- flags stay set unless a zero is written to them;
- a transmit event wins over a simultaneous clear;
- the wake-up flag rises only under its three gating conditions;
- an enabled pending error always produces code 001;
- the code and `irq` stay consistent with each other.

Some behaviours can only be shown by the bench's scenarios:
- the full priority order, and how the code moves down the order as flags are cleared;
- that disabled sources are ignored;
- that the message-error flag is excluded from the code but still raises `irq`;
- that writes of 1 have no effect;
- that the cause register is captured independently of the error flag.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
   // register addresses
   localparam int REG_FLAGS   = 0;
   localparam int REG_ENABLE  = 1;
   localparam int REG_ERRSTAT = 2;

   // error-cause bit positions inside the cause register
   localparam int ERR_RX_OVR   = 0;
   localparam int ERR_RX_WARN  = 1;
   localparam int ERR_RX_PASV  = 2;
   localparam int ERR_TX_WARN  = 3;
   localparam int ERR_TX_PASV  = 4;
   localparam int ERR_BUS_OFF  = 5;

   // flag layout derived from buffer counts
   function automatic int pos_rx(input int k);
      return k;
   endfunction
   function automatic int pos_tx(input int n_rx, input int k);
      return n_rx + k;
   endfunction
   function automatic int pos_err(input int n_rx, input int n_tx);
      return n_rx + n_tx;
   endfunction
   function automatic int pos_wake(input int n_rx, input int n_tx);
      return n_rx + n_tx + 1;
   endfunction
   function automatic int pos_merr(input int n_rx, input int n_tx);
      return n_rx + n_tx + 2;
   endfunction
endpackage

// File: rtl/can_irq_stickyreg.sv
module can_irq_stickyreg #(
   parameter int  W         = 8,
   parameter bit  ASYNC_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q_r;
   logic [W-1:0] nxt;

   if (W < 1) begin : g_bad_w
      $error("can_irq_stickyreg: W must be at least 1");
   end

   // set has precedence over a clear in the same cycle
   always_comb begin
      nxt = set_i | (q_r & ~clr_i);
   end

   if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= nxt;
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= nxt;
      end
   end

   assign q_o = q_r;
endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio #(
   parameter int N_SRC  = 7,
   parameter int CODE_W = 3
) (
   input  logic [N_SRC-1:0]  pend_i,   // index 0 is most urgent
   output logic [CODE_W-1:0] code_o
);
   if (N_SRC >= (1 << CODE_W)) begin : g_bad_code
      $error("can_irq_prio: CODE_W too narrow for N_SRC sources plus idle code");
   end

   always_comb begin
      code_o = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (pend_i[i]) code_o = CODE_W'(i + 1);
      end
   end
endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit #(
   parameter int N_RX      = 2,
   parameter int N_TX      = 3,
   parameter int N_ERR     = 6,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 2,
   parameter int CODE_W    = 3,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_RX-1:0]   ev_rx_done,
   input  logic [N_TX-1:0]   ev_tx_empty,
   input  logic [N_ERR-1:0]  ev_err_cause,
   input  logic              ev_msg_err,
   input  logic              ev_bus_act,
   input  logic              sleep_mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic [CODE_W-1:0] icode
);
   import can_irq_pkg::*;

   localparam int FLAG_W  = N_RX + N_TX + 3;
   localparam int N_CODED = N_RX + N_TX + 2;
   localparam int P_ERR   = pos_err(N_RX, N_TX);
   localparam int P_WAKE  = pos_wake(N_RX, N_TX);
   localparam int P_MERR  = pos_merr(N_RX, N_TX);

   if (FLAG_W > DATA_W) begin : g_bad_flagw
      $error("can_irq_unit: flag register wider than data port");
   end
   if (N_ERR > DATA_W) begin : g_bad_errw
      $error("can_irq_unit: error-cause register wider than data port");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("can_irq_unit: ADDR_W must cover three registers");
   end

   logic [FLAG_W-1:0]  flag_set, flag_clr, flag_q;
   logic [FLAG_W-1:0]  en_q;
   logic [N_ERR-1:0]   stat_clr, stat_q;
   logic [N_CODED-1:0] pend;
   logic               wr_flags, wr_en_reg, wr_stat;

   assign wr_flags  = wr_en && (wr_addr == ADDR_W'(REG_FLAGS));
   assign wr_en_reg = wr_en && (wr_addr == ADDR_W'(REG_ENABLE));
   assign wr_stat   = wr_en && (wr_addr == ADDR_W'(REG_ERRSTAT));

   // hardware set sources mapped into the flag layout
   for (genvar k = 0; k < N_RX; k++) begin : g_rx_set
      assign flag_set[pos_rx(k)] = ev_rx_done[k];
   end
   for (genvar k = 0; k < N_TX; k++) begin : g_tx_set
      assign flag_set[pos_tx(N_RX, k)] = ev_tx_empty[k];
   end
   assign flag_set[P_ERR]  = |ev_err_cause;
   assign flag_set[P_WAKE] = ev_bus_act && sleep_mode && en_q[P_WAKE];
   assign flag_set[P_MERR] = ev_msg_err;

   // software clear: a zero bit written to the register
   assign flag_clr = wr_flags ? ~wr_data[FLAG_W-1:0] : '0;
   assign stat_clr = wr_stat  ? ~wr_data[N_ERR-1:0]  : '0;

   can_irq_stickyreg #(.W(FLAG_W), .ASYNC_RST(ASYNC_RST)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set),
      .clr_i (flag_clr),
      .q_o   (flag_q)
   );

   can_irq_stickyreg #(.W(N_ERR), .ASYNC_RST(ASYNC_RST)) u_errstat (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_err_cause),
      .clr_i (stat_clr),
      .q_o   (stat_q)
   );

   // enable register
   if (ASYNC_RST) begin : g_en_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         en_q <= '0;
         else if (wr_en_reg) en_q <= wr_data[FLAG_W-1:0];
      end
   end else begin : g_en_sync
      always_ff @(posedge clk) begin
         if (!rst_n)         en_q <= '0;
         else if (wr_en_reg) en_q <= wr_data[FLAG_W-1:0];
      end
   end

   // priority-ordered pending vector: error, wake, TX buffers, RX buffers
   assign pend[0] = flag_q[P_ERR]  && en_q[P_ERR];
   assign pend[1] = flag_q[P_WAKE] && en_q[P_WAKE];
   for (genvar k = 0; k < N_TX; k++) begin : g_tx_pend
      assign pend[2 + k] = flag_q[pos_tx(N_RX, k)] && en_q[pos_tx(N_RX, k)];
   end
   for (genvar k = 0; k < N_RX; k++) begin : g_rx_pend
      assign pend[2 + N_TX + k] = flag_q[pos_rx(k)] && en_q[pos_rx(k)];
   end

   can_irq_prio #(.N_SRC(N_CODED), .CODE_W(CODE_W)) u_prio (
      .pend_i (pend),
      .code_o (icode)
   );

   assign irq = |(flag_q & en_q);

   // register read mux
   always_comb begin
      rd_data = '0;
      case (rd_addr)
         ADDR_W'(REG_FLAGS):   rd_data = DATA_W'(flag_q);
         ADDR_W'(REG_ENABLE):  rd_data = DATA_W'(en_q);
         ADDR_W'(REG_ERRSTAT): rd_data = DATA_W'(stat_q);
         default:              rd_data = '0;
      endcase
   end
endmodule

// File: rtl/can_irq_unit_chk.sv
module can_irq_unit_chk #(
   parameter int N_RX   = 2,
   parameter int N_TX   = 3,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int CODE_W = 3,
   parameter int FLAG_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FLAG_W-1:0] flags,
   input logic [FLAG_W-1:0] enables,
   input logic              irq,
   input logic [CODE_W-1:0] icode,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [N_TX-1:0]   ev_tx_empty,
   input logic              sleep_mode,
   input logic              ev_bus_act
);
   localparam int P_TX0  = N_RX;
   localparam int P_ERR  = N_RX + N_TX;
   localparam int P_WAKE = N_RX + N_TX + 1;

   logic wr_flags;
   assign wr_flags = wr_en && (wr_addr == '0);

   AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (icode == '0)); // R9

   AST_CODE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (icode != '0) |-> irq); // R11

   AST_ERR_TOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[P_ERR] && enables[P_ERR]) |-> (icode == CODE_W'(1))); // R8

   AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[P_WAKE]) |-> $past(enables[P_WAKE] && sleep_mode && ev_bus_act)); // R5

   AST_TX_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_empty[0] |=> flags[P_TX0]); // R2

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tx_empty[0] && wr_flags && !wr_data[P_TX0]) |=> flags[P_TX0]); // R7

   for (genvar i = 0; i < FLAG_W; i++) begin : g_hold
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !(wr_flags && !wr_data[i])) |=> flags[i]); // R6
   end
endmodule

bind can_irq_unit can_irq_unit_chk #(
   .N_RX(N_RX), .N_TX(N_TX), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .CODE_W(CODE_W), .FLAG_W(FLAG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flags       (flag_q),
   .enables     (en_q),
   .irq         (irq),
   .icode       (icode),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .ev_tx_empty (ev_tx_empty),
   .sleep_mode  (sleep_mode),
   .ev_bus_act  (ev_bus_act)
);

// File: tb/can_irq_unit_tb.sv
module can_irq_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] ev_rx_done;
   logic [2:0] ev_tx_empty;
   logic [5:0] ev_err_cause;
   logic       ev_msg_err, ev_bus_act, sleep_mode;
   logic       wr_en;
   logic [1:0] wr_addr, rd_addr;
   logic [7:0] wr_data, rd_data;
   logic       irq;
   logic [2:0] icode;

   always #(CLK_PERIOD/2) clk = ~clk;

   can_irq_unit u_dut (
      .clk(clk), .rst_n(rst_n), .ev_rx_done(ev_rx_done), .ev_tx_empty(ev_tx_empty),
      .ev_err_cause(ev_err_cause), .ev_msg_err(ev_msg_err), .ev_bus_act(ev_bus_act),
      .sleep_mode(sleep_mode), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .icode(icode)
   );

   typedef struct {
      logic [7:0] rd;
      logic       irq;
      logic [2:0] code;
      string      tag;
   } item_t;

   item_t q[$];
   int    checks = 0;
   int    errors = 0;
   bit    done   = 0;

   // reference state built from the requirements
   logic [7:0] mf, me;
   logic [5:0] ms;

   function automatic logic [2:0] exp_code(input logic [7:0] f, input logic [7:0] e);
      logic [7:0] p;
      p = f & e;
      if (p[5]) return 3'd1;      // error
      if (p[6]) return 3'd2;      // wake
      if (p[2]) return 3'd3;      // TX0
      if (p[3]) return 3'd4;      // TX1
      if (p[4]) return 3'd5;      // TX2
      if (p[0]) return 3'd6;      // RX0
      if (p[1]) return 3'd7;      // RX1
      return 3'd0;
   endfunction

   // monitor: pop expected items and compare away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (rd_data !== it.rd || irq !== it.irq || icode !== it.code) begin
               errors++;
               $display("FAIL %s: actual rd=%02h irq=%0b code=%0d expected rd=%02h irq=%0b code=%0d",
                        it.tag, rd_data, irq, icode, it.rd, it.irq, it.code);
            end
         end
      end
   end

   // driver: observe one register, pushing the expected item
   task automatic obs(input logic [1:0] a, input string tag);
      item_t it;
      rd_addr = a;
      it.rd   = (a == 2'd0) ? mf : (a == 2'd1) ? me : (a == 2'd2) ? {2'b00, ms} : 8'h00;
      it.irq  = |(mf & me);
      it.code = exp_code(mf, me);
      it.tag  = tag;
      q.push_back(it);
      @(posedge clk); #1;
   endtask

   // one cycle of stimulus with an optional register write
   task automatic step(input logic [1:0] rx, input logic [2:0] tx, input logic [5:0] er,
                       input logic merr, input logic act,
                       input logic we, input logic [1:0] wa, input logic [7:0] wd);
      logic [7:0] set, clr;
      ev_rx_done = rx; ev_tx_empty = tx; ev_err_cause = er;
      ev_msg_err = merr; ev_bus_act = act;
      wr_en = we; wr_addr = wa; wr_data = wd;
      set = {merr, act & sleep_mode & me[6], |er, tx, rx};
      clr = (we && wa == 2'd0) ? ~wd : 8'h00;
      @(posedge clk);
      mf = set | (mf & ~clr);
      if (we && wa == 2'd1) me = wd;
      ms = er | (ms & ((we && wa == 2'd2) ? wd[5:0] : 6'h3f));
      #1;
      ev_rx_done = '0; ev_tx_empty = '0; ev_err_cause = '0;
      ev_msg_err = 1'b0; ev_bus_act = 1'b0; wr_en = 1'b0; wr_data = '0; wr_addr = '0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      step(2'b0, 3'b0, 6'b0, 1'b0, 1'b0, 1'b1, a, d);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         errors++;
         $display("FAIL timeout: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sleep_mode = 1'b0; rd_addr = '0;
      ev_rx_done = '0; ev_tx_empty = '0; ev_err_cause = '0;
      ev_msg_err = 1'b0; ev_bus_act = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      mf = '0; me = '0; ms = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      obs(2'd0, "R1 flags after reset");
      obs(2'd1, "R1 enables after reset");
      obs(2'd2, "R1 cause after reset");

      wr(2'd1, 8'hff);
      obs(2'd1, "R12 enable readback");

      step(2'b00, 3'b010, 6'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h0);
      obs(2'd0, "R2 TX1 flag code 100");
      step(2'b10, 3'b000, 6'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h0);
      obs(2'd0, "R8 RX1 below TX1");
      step(2'b00, 3'b000, 6'b000100, 1'b0, 1'b0, 1'b0, 2'd0, 8'h0);
      obs(2'd0, "R3 error flag code 001");
      obs(2'd2, "R3 cause bit 2 captured");

      wr(2'd0, 8'hdf);
      obs(2'd0, "R10 code falls back to TX1");
      obs(2'd2, "R3 cause kept after flag clear");
      wr(2'd2, 8'h00);
      obs(2'd2, "R3 cause cleared by zero write");

      wr(2'd1, 8'hf7);
      obs(2'd0, "R9 disabled TX1 ignored code 111");

      wr(2'd0, 8'hff);
      obs(2'd0, "R6 write of ones changes nothing");
      wr(2'd0, 8'h00);
      obs(2'd0, "R6 zero write clears all");

      wr(2'd1, 8'h80);
      step(2'b00, 3'b000, 6'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'h0);
      obs(2'd0, "R4 message error irq with code 000");
      wr(2'd1, 8'h00);
      obs(2'd0, "R11 disabled message error drops irq");
      wr(2'd0, 8'h00);

      sleep_mode = 1'b1;
      step(2'b00, 3'b000, 6'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'h0);
      obs(2'd0, "R5 wake ignored while disabled");
      wr(2'd1, 8'hff);
      sleep_mode = 1'b0;
      step(2'b00, 3'b000, 6'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'h0);
      obs(2'd0, "R5 wake ignored while awake");
      sleep_mode = 1'b1;
      step(2'b00, 3'b000, 6'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'h0);
      obs(2'd0, "R5 wake flag code 010");
      sleep_mode = 1'b0;

      step(2'b00, 3'b001, 6'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'h00);
      obs(2'd0, "R7 TX0 set beats clear");

      step(2'b01, 3'b100, 6'b100000, 1'b0, 1'b0, 1'b0, 2'd0, 8'h0);
      obs(2'd0, "R8 error over TX0 TX2 RX0");
      obs(2'd2, "R3 bus-off cause bit 5");
      wr(2'd0, 8'hdf);
      obs(2'd0, "R10 next is TX0 code 011");
      wr(2'd0, 8'hdb);
      obs(2'd0, "R10 next is TX2 code 101");
      wr(2'd0, 8'hcb);
      obs(2'd0, "R10 next is RX0 code 110");
      wr(2'd0, 8'h00);
      obs(2'd0, "R9 nothing pending code 000");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule